// File: doc/BRIEF.md
# Strobed Host Bus Front End with Vectored Interrupt Acknowledge

This block sits between a host bus that uses separate address and data strobes and the register space of a peripheral. When the address strobe ends, it captures the register address, the active-low select and the active-low interrupt-acknowledge line. The data strobe that follows carries the transfer. A read returns the addressed register, and the data bus drivers are enabled only while the data strobe is held and the active-high select is asserted. A write stores the data bus into the addressed register when the data strobe ends. Both strobes pass through a synchroniser clocked by the system clock, and all edges are taken from the synchronised copies.

If the acknowledge line was captured asserted, the cycle is an interrupt acknowledge instead. In that case the address, both selects and the direction line have no effect. When the data strobe falls, the block looks at the priority chain. If the chain enable input is high and a source is waiting, the block marks the highest-priority waiting source as in service. It then drives that source's vector, which is the programmed base with the source number placed in bits 3:1. Source 0 has the highest priority. A source that is in service blocks requests from itself and from every lower source. Host software releases the source by writing a release command.

Top module: `strobe_bus_front`

## Requirements
- R1: After reset the data drivers are off, the request output is high, the chain output follows the chain input, and the status register reads 0x00.
- R2: Address, select and acknowledge are sampled when the address strobe rises. Changes to them after that point do not alter the cycle.
- R3: A cycle whose direction line is high at the data-strobe fall is a read. It returns the addressed register, and the drivers are on only while the data strobe is low and the active-high select is high.
- R4: A write stores the data bus when the data strobe rises. Scratch register is at 0x05, vector base at 0x0C. Writes to unused addresses change nothing, and reads of them return 0x00.
- R5: If the active-low select was high when the address strobe rose, the cycle neither writes nor drives.
- R6: A one-clock pulse on a source's event input makes it pending. Status at 0x00 reads pending flags in bits 3:0 and in-service flags in bits 7:4, with bit index equal to the source number.
- R7: The request output is low exactly when some source is pending and not in service, the chain input is high, and no source of equal or higher priority is in service.
- R8: In an acknowledge cycle with the chain input high and a requesting source, the highest-priority requester becomes in service. Its vector, which is the base with bits 3:1 replaced by the source number, is driven while the data strobe is low. Address, selects and direction have no effect.
- R9: An acknowledge cycle with the chain input low, or with no requesting source, changes no flag and does not drive.
- R10: The chain output is low whenever any source is in service or pending. Otherwise it equals the chain input.
- R11: Writing a value with bit 0 set to address 0x0E clears the in-service flag and the pending flag of the highest-priority in-service source. If bit 0 is clear, the write does nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| adr_stb_n | input | 1 | Address strobe, active low, sampled on its rising edge |
| dat_stb_n | input | 1 | Data strobe, active low |
| rd_wr | input | 1 | High selects read, low selects write |
| sel_n | input | 1 | Active-low select, latched with the address |
| sel_hi | input | 1 | Active-high select gating the read drivers |
| iack_n | input | 1 | Active-low interrupt acknowledge, latched with the address |
| addr_i | input | ADDR_W | Register address |
| data_i | input | DATA_W | Write data from the bus |
| data_o | output | DATA_W | Read data or vector |
| data_oe | output | 1 | Enable for the bus drivers |
| chain_in | input | 1 | Priority chain enable input |
| chain_out | output | 1 | Priority chain enable output |
| irq_n | output | 1 | Active-low interrupt request |
| src_evt | input | NSRC | Per-source event pulses |

## Verification
Each strobe edge takes effect on the third rising clock edge after the pin changes: two synchroniser stages and one edge register. The flags, the stored data and the driver enable are therefore settled on the fourth clock. The bench holds every strobe level for at least four clocks and samples at the falling edge of the fifth. The request and chain outputs are combinational from the flag registers and the chain input. They are checked one clock after a source pulse, or directly after a change of the chain input, on a falling edge.

// File: rtl/sbf_pkg.sv
package sbf_pkg;

   // Kind of bus cycle captured at the address-strobe rising edge.
   typedef enum logic [1:0] {
      CYC_NONE = 2'd0,
      CYC_REG  = 2'd1,
      CYC_ACK  = 2'd2,
      CYC_SKIP = 2'd3
   } cyc_kind_e;

   // Width of the source-number field placed into the vector.
   localparam int unsigned VEC_IDX_W = 3;
   localparam int unsigned VEC_IDX_LSB = 1;

endpackage

// File: rtl/sbf_strobe_sync.sv
module sbf_strobe_sync #(
   parameter int unsigned N_SIG  = 2,
   parameter int unsigned STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [N_SIG-1:0] raw_n,
   output logic [N_SIG-1:0] lvl_n,
   output logic [N_SIG-1:0] rise,
   output logic [N_SIG-1:0] fall
);

   localparam int unsigned DEPTH = STAGES + 1;

   if (STAGES < 2) begin : g_bad_stages
      $error("sbf_strobe_sync: STAGES must be at least 2");
   end

   logic [N_SIG-1:0] stg [DEPTH];

   for (genvar g = 0; g < DEPTH; g++) begin : g_stage
      if (g == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stg[g] <= '1;
            else        stg[g] <= raw_n;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stg[g] <= '1;
            else        stg[g] <= stg[g-1];
         end
      end
   end

   assign lvl_n = stg[STAGES-1];
   assign rise  =  stg[STAGES-1] & ~stg[STAGES];
   assign fall  = ~stg[STAGES-1] &  stg[STAGES];

endmodule

// File: rtl/sbf_irq_chain.sv
module sbf_irq_chain
   import sbf_pkg::*;
#(
   parameter int unsigned NSRC        = 4,
   parameter int unsigned DATA_W      = 8,
   parameter bit          VEC_HAS_SRC = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NSRC-1:0]   src_evt,
   input  logic              chain_in,
   input  logic              ack_take,
   input  logic              svc_clear,
   input  logic [DATA_W-1:0] vbase,
   output logic [NSRC-1:0]   pend,
   output logic [NSRC-1:0]   ius,
   output logic              req_any,
   output logic [DATA_W-1:0] vec,
   output logic              irq_n,
   output logic              chain_out
);

   logic [NSRC-1:0] pend_q, ius_q;
   logic [NSRC-1:0] cand, clr_sel, set_sel, clr_mask;
   logic [VEC_IDX_W-1:0] sel_idx;
   logic blocked, seen;

   // Priority walk: lowest index first. A pending or in-service source
   // blocks everything below it; an in-service source also blocks itself.
   always_comb begin
      blocked = ~chain_in;
      seen    = 1'b0;
      cand    = '0;
      clr_sel = '0;
      sel_idx = '0;
      for (int i = 0; i < int'(NSRC); i++) begin
         if (pend_q[i] && !ius_q[i] && !blocked) begin
            cand[i] = 1'b1;
            sel_idx = VEC_IDX_W'(i);
         end
         if (pend_q[i] || ius_q[i]) blocked = 1'b1;
         if (ius_q[i] && !seen) clr_sel[i] = 1'b1;
         if (ius_q[i]) seen = 1'b1;
      end
   end

   assign req_any  = |cand;
   assign set_sel  = ack_take ? cand : '0;
   assign clr_mask = svc_clear ? clr_sel : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_q <= '0;
         ius_q  <= '0;
      end else begin
         pend_q <= (pend_q & ~clr_mask) | src_evt;
         ius_q  <= (ius_q & ~clr_mask) | set_sel;
      end
   end

   if (VEC_HAS_SRC) begin : g_vec_src
      always_comb begin
         vec = vbase;
         vec[VEC_IDX_LSB +: VEC_IDX_W] = sel_idx;
      end
   end else begin : g_vec_flat
      logic unused_idx;
      assign unused_idx = ^sel_idx;
      assign vec = vbase;
   end

   assign pend      = pend_q;
   assign ius       = ius_q;
   assign irq_n     = ~req_any;
   assign chain_out = chain_in & ~(|ius_q) & ~(|pend_q);

endmodule

// File: rtl/sbf_regfile.sv
module sbf_regfile #(
   parameter int unsigned ADDR_W  = 8,
   parameter int unsigned DATA_W  = 8,
   parameter int unsigned NSRC    = 4,
   parameter int unsigned A_STAT  = 'h00,
   parameter int unsigned A_SCR   = 'h05,
   parameter int unsigned A_VBASE = 'h0C,
   parameter int unsigned A_CMD   = 'h0E
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [NSRC-1:0]   pend,
   input  logic [NSRC-1:0]   ius,
   output logic [DATA_W-1:0] vbase,
   output logic [DATA_W-1:0] rd_data,
   output logic              svc_clear
);

   localparam logic [ADDR_W-1:0] AD_STAT  = ADDR_W'(A_STAT);
   localparam logic [ADDR_W-1:0] AD_SCR   = ADDR_W'(A_SCR);
   localparam logic [ADDR_W-1:0] AD_VBASE = ADDR_W'(A_VBASE);
   localparam logic [ADDR_W-1:0] AD_CMD   = ADDR_W'(A_CMD);
   localparam int unsigned STAT_W = 2 * NSRC;

   logic [DATA_W-1:0] scr_q, vbase_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scr_q   <= '0;
         vbase_q <= '0;
      end else if (wr_en) begin
         if (addr == AD_SCR)   scr_q   <= wr_data;
         if (addr == AD_VBASE) vbase_q <= wr_data;
      end
   end

   assign svc_clear = wr_en && (addr == AD_CMD) && wr_data[0];

   always_comb begin
      rd_data = '0;
      unique case (addr)
         AD_STAT:  rd_data[STAT_W-1:0] = {ius, pend};
         AD_SCR:   rd_data = scr_q;
         AD_VBASE: rd_data = vbase_q;
         default:  rd_data = '0;
      endcase
   end

   assign vbase = vbase_q;

endmodule

// File: rtl/strobe_bus_front.sv
module strobe_bus_front
   import sbf_pkg::*;
#(
   parameter int unsigned ADDR_W      = 8,
   parameter int unsigned DATA_W      = 8,
   parameter int unsigned NSRC        = 4,
   parameter int unsigned SYNC_STAGES = 2,
   parameter bit          VEC_HAS_SRC = 1'b1,
   parameter int unsigned A_STAT      = 'h00,
   parameter int unsigned A_SCR       = 'h05,
   parameter int unsigned A_VBASE     = 'h0C,
   parameter int unsigned A_CMD       = 'h0E
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              adr_stb_n,
   input  logic              dat_stb_n,
   input  logic              rd_wr,
   input  logic              sel_n,
   input  logic              sel_hi,
   input  logic              iack_n,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic [DATA_W-1:0] data_i,
   output logic [DATA_W-1:0] data_o,
   output logic              data_oe,
   input  logic              chain_in,
   output logic              chain_out,
   output logic              irq_n,
   input  logic [NSRC-1:0]   src_evt
);

   localparam int unsigned STB_AS = 0;
   localparam int unsigned STB_DS = 1;

   if (NSRC < 1 || NSRC > (1 << VEC_IDX_W)) begin : g_bad_nsrc
      $error("strobe_bus_front: NSRC out of range for the vector field");
   end
   if (DATA_W < VEC_IDX_LSB + VEC_IDX_W || 2 * NSRC > DATA_W) begin : g_bad_dw
      $error("strobe_bus_front: DATA_W too narrow for vector or status");
   end
   if (ADDR_W < 1 || ADDR_W > 16) begin : g_bad_aw
      $error("strobe_bus_front: ADDR_W out of range");
   end

   // Strobe synchronisation and edge detection
   logic [1:0] stb_lvl_n, stb_rise, stb_fall;

   sbf_strobe_sync #(
      .N_SIG  (2),
      .STAGES (SYNC_STAGES)
   ) sync_i (
      .clk   (clk),
      .rst_n (rst_n),
      .raw_n ({dat_stb_n, adr_stb_n}),
      .lvl_n (stb_lvl_n),
      .rise  (stb_rise),
      .fall  (stb_fall)
   );

   logic as_rise, ds_fall, ds_rise, unused_lvl;
   assign as_rise    = stb_rise[STB_AS];
   assign ds_fall    = stb_fall[STB_DS];
   assign ds_rise    = stb_rise[STB_DS];
   assign unused_lvl = ^{stb_lvl_n, stb_fall[STB_AS], stb_rise[STB_AS] & 1'b0};

   // Cycle capture state
   cyc_kind_e         cyc_kind;
   logic [ADDR_W-1:0] cyc_addr;
   logic              cyc_read, ds_act, ack_hit_q;
   logic [DATA_W-1:0] dout_q;

   logic              ack_take, wr_en, svc_clear, req_any, in_ack_cyc;
   logic [NSRC-1:0]   pend, ius;
   logic [DATA_W-1:0] vbase, rd_data, vec;

   assign in_ack_cyc = (cyc_kind == CYC_ACK);
   assign ack_take   = ds_fall && !ds_act && in_ack_cyc;
   assign wr_en      = ds_rise && ds_act && (cyc_kind == CYC_REG) && !cyc_read;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cyc_kind  <= CYC_NONE;
         cyc_addr  <= '0;
         cyc_read  <= 1'b0;
         ds_act    <= 1'b0;
         ack_hit_q <= 1'b0;
         dout_q    <= '0;
      end else begin
         if (as_rise && !ds_act) begin
            cyc_addr <= addr_i;
            if (!iack_n)     cyc_kind <= CYC_ACK;
            else if (!sel_n) cyc_kind <= CYC_REG;
            else             cyc_kind <= CYC_SKIP;
         end
         if (ds_fall && !ds_act && cyc_kind != CYC_NONE) begin
            ds_act <= 1'b1;
            if (in_ack_cyc) begin
               cyc_read  <= 1'b0;
               ack_hit_q <= req_any;
               dout_q    <= vec;
            end else begin
               cyc_read  <= rd_wr;
               ack_hit_q <= 1'b0;
               if (rd_wr) dout_q <= rd_data;
            end
         end
         if (ds_rise && ds_act) begin
            ds_act    <= 1'b0;
            ack_hit_q <= 1'b0;
            cyc_read  <= 1'b0;
            cyc_kind  <= CYC_NONE;
         end
      end
   end

   sbf_regfile #(
      .ADDR_W  (ADDR_W),
      .DATA_W  (DATA_W),
      .NSRC    (NSRC),
      .A_STAT  (A_STAT),
      .A_SCR   (A_SCR),
      .A_VBASE (A_VBASE),
      .A_CMD   (A_CMD)
   ) regs_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (wr_en),
      .addr      (cyc_addr),
      .wr_data   (data_i),
      .pend      (pend),
      .ius       (ius),
      .vbase     (vbase),
      .rd_data   (rd_data),
      .svc_clear (svc_clear)
   );

   sbf_irq_chain #(
      .NSRC        (NSRC),
      .DATA_W      (DATA_W),
      .VEC_HAS_SRC (VEC_HAS_SRC)
   ) chain_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .src_evt   (src_evt),
      .chain_in  (chain_in),
      .ack_take  (ack_take),
      .svc_clear (svc_clear),
      .vbase     (vbase),
      .pend      (pend),
      .ius       (ius),
      .req_any   (req_any),
      .vec       (vec),
      .irq_n     (irq_n),
      .chain_out (chain_out)
   );

   assign data_o  = dout_q;
   assign data_oe = ds_act &&
                    (in_ack_cyc ? ack_hit_q
                                : (cyc_kind == CYC_REG && cyc_read && sel_hi));

endmodule

// File: rtl/sbf_checker.sv
module sbf_checker #(
   parameter int unsigned NSRC = 4
) (
   input logic            clk,
   input logic            rst_n,
   input logic            irq_n,
   input logic            chain_in,
   input logic            chain_out,
   input logic            data_oe,
   input logic            sel_hi,
   input logic            in_ack,
   input logic [NSRC-1:0] ius
);

   // R7
   irq_needs_chain_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !irq_n |-> chain_in);

   // R10
   chain_blocked_by_svc_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ius != '0) |-> !chain_out);

   // R8
   svc_only_in_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((ius & ~$past(ius)) != '0) |-> $past(in_ack));

   // R8
   svc_single_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(ius & ~$past(ius)) <= 1);

   // R11
   svc_single_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $countones($past(ius) & ~ius) <= 1);

   // R3
   drive_needs_select_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (data_oe && !in_ack) |-> sel_hi);

endmodule

bind strobe_bus_front sbf_checker #(.NSRC(NSRC)) chk_i (
   .clk       (clk),
   .rst_n     (rst_n),
   .irq_n     (irq_n),
   .chain_in  (chain_in),
   .chain_out (chain_out),
   .data_oe   (data_oe),
   .sel_hi    (sel_hi),
   .in_ack    (in_ack_cyc),
   .ius       (ius)
);

// File: tb/strobe_bus_front_tb_top.sv
module strobe_bus_front_tb_top;

   localparam logic [7:0] A_STAT  = 8'h00;
   localparam logic [7:0] A_SCR   = 8'h05;
   localparam logic [7:0] A_VBASE = 8'h0C;
   localparam logic [7:0] A_CMD   = 8'h0E;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic adr_stb_n = 1'b1, dat_stb_n = 1'b1, rd_wr = 1'b1;
   logic sel_n = 1'b1, sel_hi = 1'b1, iack_n = 1'b1;
   logic [7:0] addr_i = '0, data_i = '0;
   logic [7:0] data_o;
   logic data_oe, chain_out, irq_n;
   logic chain_in = 1'b1;
   logic [3:0] src_evt = '0;

   int checks = 0;
   int failures = 0;
   bit finished = 1'b0;

   always #10 clk = ~clk;

   strobe_bus_front dut_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .adr_stb_n (adr_stb_n),
      .dat_stb_n (dat_stb_n),
      .rd_wr     (rd_wr),
      .sel_n     (sel_n),
      .sel_hi    (sel_hi),
      .iack_n    (iack_n),
      .addr_i    (addr_i),
      .data_i    (data_i),
      .data_o    (data_o),
      .data_oe   (data_oe),
      .chain_in  (chain_in),
      .chain_out (chain_out),
      .irq_n     (irq_n),
      .src_evt   (src_evt)
   );

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // One full bus cycle. a_late/sel changes after the address strobe rise test latching.
   task automatic bus_cycle(input logic ack, input logic sel, input logic [7:0] a,
                            input logic rd, input logic [7:0] wd, input logic [7:0] a_late,
                            output logic [7:0] rdat, output logic oe);
      tick(1);
      addr_i = a; sel_n = ~sel; iack_n = ~ack; adr_stb_n = 1'b0;
      tick(4);
      adr_stb_n = 1'b1;
      tick(4);
      addr_i = a_late; sel_n = 1'b1; iack_n = 1'b1;
      rd_wr = rd; data_i = wd; dat_stb_n = 1'b0;
      tick(5);
      rdat = data_o; oe = data_oe;
      dat_stb_n = 1'b1;
      tick(5);
      rd_wr = 1'b1;
   endtask

   task automatic wr(input logic [7:0] a, input logic [7:0] d);
      logic [7:0] r; logic o;
      bus_cycle(1'b0, 1'b1, a, 1'b0, d, a, r, o);
   endtask

   task automatic rd(input logic [7:0] a, output logic [7:0] d, output logic o);
      bus_cycle(1'b0, 1'b1, a, 1'b1, 8'h00, a, d, o);
   endtask

   task automatic pulse(input logic [3:0] m);
      tick(1); src_evt = m; tick(1); src_evt = '0; tick(1);
   endtask

   task automatic t_reset;
      logic [7:0] d; logic o;
      check("R1 oe", {7'd0, data_oe}, 8'h00);
      check("R1 irq_n", {7'd0, irq_n}, 8'h01);
      check("R1 chain_out", {7'd0, chain_out}, 8'h01);
      rd(A_STAT, d, o);
      check("R1 status", d, 8'h00);
   endtask

   task automatic t_regs;
      logic [7:0] d; logic o;
      wr(A_SCR, 8'hA5);
      wr(A_VBASE, 8'h61);
      rd(A_SCR, d, o);
      check("R4 scratch", d, 8'hA5);
      check("R3 oe on read", {7'd0, o}, 8'h01);
      rd(A_VBASE, d, o);
      check("R4 vbase", d, 8'h61);
      wr(8'h40, 8'h33);
      rd(8'h40, d, o);
      check("R4 unused read", d, 8'h00);
      rd(A_SCR, d, o);
      check("R4 unused write no effect", d, 8'hA5);
      sel_hi = 1'b0;
      rd(A_SCR, d, o);
      sel_hi = 1'b1;
      check("R3 oe gated by sel_hi", {7'd0, o}, 8'h00);
   endtask

   task automatic t_deselect;
      logic [7:0] d; logic o;
      bus_cycle(1'b0, 1'b0, A_SCR, 1'b0, 8'h11, A_SCR, d, o);
      bus_cycle(1'b0, 1'b0, A_SCR, 1'b1, 8'h00, A_SCR, d, o);
      check("R5 no drive when deselected", {7'd0, o}, 8'h00);
      rd(A_SCR, d, o);
      check("R5 no write when deselected", d, 8'hA5);
   endtask

   task automatic t_latch;
      logic [7:0] d; logic o;
      bus_cycle(1'b0, 1'b1, A_SCR, 1'b0, 8'h3C, A_VBASE, d, o);
      rd(A_SCR, d, o);
      check("R2 latched address written", d, 8'h3C);
      rd(A_VBASE, d, o);
      check("R2 late address ignored", d, 8'h61);
   endtask

   task automatic t_pending;
      logic [7:0] d; logic o;
      pulse(4'b0110);
      check("R7 irq_n low", {7'd0, irq_n}, 8'h00);
      check("R10 chain_out low on pending", {7'd0, chain_out}, 8'h00);
      rd(A_STAT, d, o);
      check("R6 status pending", d, 8'h06);
   endtask

   task automatic t_chain_off;
      logic [7:0] d; logic o;
      chain_in = 1'b0;
      tick(1);
      check("R7 irq_n high with chain low", {7'd0, irq_n}, 8'h01);
      bus_cycle(1'b1, 1'b1, A_SCR, 1'b1, 8'h00, A_SCR, d, o);
      check("R9 no drive with chain low", {7'd0, o}, 8'h00);
      chain_in = 1'b1;
      rd(A_STAT, d, o);
      check("R9 flags unchanged", d, 8'h06);
   endtask

   task automatic t_ack_seq;
      logic [7:0] d; logic o;
      sel_hi = 1'b0;
      bus_cycle(1'b1, 1'b0, 8'hFF, 1'b0, 8'h00, 8'h77, d, o);
      sel_hi = 1'b1;
      check("R8 vector src1", d, 8'h63);
      check("R8 driven despite selects", {7'd0, o}, 8'h01);
      check("R7 lower source blocked", {7'd0, irq_n}, 8'h01);
      rd(A_STAT, d, o);
      check("R8 status after ack", d, 8'h26);
      wr(A_CMD, 8'h00);
      rd(A_STAT, d, o);
      check("R11 bit0 clear no effect", d, 8'h26);
      wr(A_CMD, 8'h01);
      rd(A_STAT, d, o);
      check("R11 release src1", d, 8'h04);
      check("R7 src2 requests", {7'd0, irq_n}, 8'h00);
      bus_cycle(1'b1, 1'b1, A_SCR, 1'b1, 8'h00, A_SCR, d, o);
      check("R8 vector src2", d, 8'h65);
      pulse(4'b0001);
      check("R7 higher source requests over service", {7'd0, irq_n}, 8'h00);
      bus_cycle(1'b1, 1'b1, A_SCR, 1'b1, 8'h00, A_SCR, d, o);
      check("R8 vector src0", d, 8'h61);
      rd(A_STAT, d, o);
      check("R8 nested status", d, 8'h55);
      wr(A_CMD, 8'h01);
      rd(A_STAT, d, o);
      check("R11 release highest first", d, 8'h44);
      wr(A_CMD, 8'h01);
      rd(A_STAT, d, o);
      check("R11 all released", d, 8'h00);
      check("R10 chain passes through", {7'd0, chain_out}, 8'h01);
      bus_cycle(1'b1, 1'b1, A_SCR, 1'b1, 8'h00, A_SCR, d, o);
      check("R9 no drive when idle", {7'd0, o}, 8'h00);
      rd(A_STAT, d, o);
      check("R9 idle ack leaves flags", d, 8'h00);
   endtask

   initial begin
      tick(3);
      rst_n = 1'b1;
      tick(2);
      t_reset();
      t_regs();
      t_deselect();
      t_latch();
      t_pending();
      t_chain_off();
      t_ack_seq();
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         checks++;
         failures++;
         $display("FAIL watchdog actual=%h expected=%h", 8'h00, 8'h01);
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

endmodule